// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI master from its faster module clock. A 13-bit control word chooses how the rate is set. The linear scheme divides by an even number, 2·(N+1). The exponential scheme divides by a power of two, 2^M. The transfer engine raises a run enable while a transfer is under way. While run enable is low, the serial clock rests at the level given by the clock polarity input.

Besides the clock itself, the block emits two single-cycle strobes for the shift logic. One marks each move from the idle level to the active level. The other marks each return to idle. The shift logic samples and launches data on these strobes, so it never has to watch the serial clock directly.

The control word is captured only while the clock is stopped. A rate change therefore cannot tear a half-period in the middle of a transfer.

Top module: `spi_sclk_divider`

## Requirements
- R1: With mode bit 12 = 1, the serial clock spends exactly N+1 module-clock cycles at each level, where N is control-word bits 7:0. The full period is therefore 2·(N+1) cycles, and N=0 gives divide-by-2.
- R2: With mode bit 12 = 0 and M ≥ 1, the serial clock spends 2^(M−1) module-clock cycles at each level, where M is control-word bits 11:8. The full period is therefore 2^M cycles.
- R3: Bit 12 alone picks the scheme. With bit 12 = 1 the exponent field has no effect on the rate, and with bit 12 = 0 the linear field has no effect.
- R4: In exponential mode with M=0 the block divides by 2 (one cycle per level). It never passes the undivided module clock through.
- R5: Whenever run enable is low, and from reset, the serial clock equals the polarity input: low for polarity 0, high for polarity 1. While running, the active level is the opposite of that input.
- R6: After run enable rises, the first idle-to-active edge arrives one full half-period later. Measured from the first rising module-clock edge that samples run enable high, this is N+1 cycles in linear mode or the exponential half-period otherwise.
- R7: A change to the control word while run enable is high does not alter the running rate. The new value is used only after the clock has been stopped and restarted.
- R8: The leading strobe is high for exactly one module-clock cycle, in the cycle where the serial clock first shows its active level. The trailing strobe is high for exactly one cycle when the clock returns to idle, and this includes a return forced by dropping run enable. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ctl | input | 13 | Control word: [7:0] linear N, [11:8] exponent M, [12] mode (1 = linear) |
| run_en | input | 1 | High while the transfer engine wants the serial clock running |
| cpol | input | 1 | Clock polarity; sets the idle level |
| sclk | output | 1 | Serial clock |
| lead_pulse | output | 1 | One-cycle strobe on each idle-to-active transition |
| trail_pulse | output | 1 | One-cycle strobe on each active-to-idle transition |

## Verification
The bench measures the number of cycles from start to the first edge, and from edge to edge, for several settings:

- Linear settings N=0, 3 and 9 separate the +1 offset from a plain divide-by-N.
- Exponential settings M=0, 1, 3 and 6 separate the special M=0 case from the 2^(M−1) law.
- Control words that load the unused field with a large value show that the mode bit, not the other field, sets the rate.
- A rate change during a run, a stop while the clock is active, and runs with both polarities separate a correct capture-while-idle, forced trailing strobe and idle level from designs that follow the input live or ignore the polarity.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  localparam int N_W      = 8;
  localparam int M_W      = 4;
  localparam int MODE_BIT = N_W + M_W;
  localparam int CTL_W    = N_W + M_W + 1;
  localparam int EXP_HP_W = (1 << M_W) - 1;
  localparam int HP_W     = (EXP_HP_W > N_W + 1) ? EXP_HP_W : N_W + 1;

  typedef logic [CTL_W-1:0] ctl_t;
  typedef logic [HP_W-1:0]  half_t;

  // cycles per serial-clock level for a given control word
  function automatic half_t half_len(input ctl_t ctl);
    logic [M_W-1:0] m;
    m = ctl[N_W+M_W-1:N_W];
    if (ctl[MODE_BIT])
      return {{(HP_W-N_W){1'b0}}, ctl[N_W-1:0]} + half_t'(1);
    else if (m == '0)
      return half_t'(1);
    else
      return half_t'(1) << (m - 1'b1);
  endfunction
endpackage

// File: rtl/sdiv_cfg_latch.sv
module sdiv_cfg_latch
  import spi_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_en,
  input  ctl_t  clk_ctl,
  output ctl_t  cfg_q,
  output half_t half
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (!run_en) cfg_q <= clk_ctl;
  end

  assign half = half_len(cfg_q);
endmodule

// File: rtl/sdiv_counter.sv
module sdiv_counter
  import spi_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_en,
  input  half_t half,
  output half_t cnt,
  output logic  tick
);
  assign tick = run_en && (cnt == half - half_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run_en) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + half_t'(1);
  end
endmodule

// File: rtl/sdiv_edge_gen.sv
module sdiv_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic tick,
  output logic active,
  output logic lead,
  output logic trail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      lead   <= 1'b0;
      trail  <= 1'b0;
    end else if (!run_en) begin
      active <= 1'b0;
      lead   <= 1'b0;
      trail  <= active;
    end else if (tick) begin
      active <= ~active;
      lead   <= ~active;
      trail  <= active;
    end else begin
      lead   <= 1'b0;
      trail  <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spi_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] clk_ctl,
  input  logic             run_en,
  input  logic             cpol,
  output logic             sclk,
  output logic             lead_pulse,
  output logic             trail_pulse
);
  ctl_t  cfg_q;
  half_t half;
  half_t cnt;
  logic  tick;
  logic  active;

  sdiv_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_ctl(clk_ctl),
    .cfg_q(cfg_q), .half(half)
  );

  sdiv_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .half(half),
    .cnt(cnt), .tick(tick)
  );

  sdiv_edge_gen u_edge (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
    .active(active), .lead(lead_pulse), .trail(trail_pulse)
  );

  assign sclk = cpol ^ active;
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker
  import spi_div_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  run_en,
  input logic  cpol,
  input logic  sclk,
  input logic  lead,
  input logic  trail,
  input logic  active,
  input half_t cnt,
  input half_t half,
  input ctl_t  cfg_q
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < half); // R1
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (sclk == cpol)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en)) |-> $stable(cfg_q)); // R7
  AST_LEAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> lead); // R8
  AST_TRAIL_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> trail); // R8
  AST_LEAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lead |=> !lead); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead && trail)); // R8
endmodule

bind spi_sclk_divider sdiv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cpol(cpol), .sclk(sclk),
  .lead(lead_pulse), .trail(trail_pulse), .active(active),
  .cnt(cnt), .half(half), .cfg_q(cfg_q)
);

// File: tb/sim_spi_sclk_divider.sv
module sim_spi_sclk_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] clk_ctl = '0;
  logic        run_en = 1'b0;
  logic        cpol = 1'b0;
  logic        sclk, lead_pulse, trail_pulse;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  spi_sclk_divider u0 (
    .clk(clk), .rst_n(rst_n), .clk_ctl(clk_ctl), .run_en(run_en),
    .cpol(cpol), .sclk(sclk), .lead_pulse(lead_pulse), .trail_pulse(trail_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_half(input logic [12:0] c);
    if (c[12]) return int'(c[7:0]) + 1;
    if (c[11:8] == 4'd0) return 1;
    return (2 ** int'(c[11:8])) / 2;
  endfunction

  // negedges until the given strobe appears (1 = lead, 0 = trail)
  task automatic wait_strobe(input bit want_lead, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!(want_lead ? lead_pulse : trail_pulse) && k < 40000);
  endtask

  task automatic stop_idle();
    @(negedge clk);
    run_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(input string req, input logic [12:0] c, input logic pol);
    int k, h;
    h = exp_half(c);
    clk_ctl = c;
    cpol = pol;
    repeat (3) @(negedge clk);
    check(req, sclk, pol);
    run_en = 1'b1;
    wait_strobe(1'b1, k);
    check({req, " R6 first edge"}, k, h);
    check({req, " R5 active level"}, sclk, !pol);
    wait_strobe(1'b0, k);
    check({req, " trail spacing"}, k, h);
    check({req, " R5 idle level"}, sclk, pol);
    wait_strobe(1'b1, k);
    check({req, " lead spacing"}, k, h);
    @(negedge clk);
    check("R8 lead width", lead_pulse, (h == 1) ? 0 : 0);
    stop_idle();
    check({req, " R5 stopped"}, sclk, pol);
  endtask

  task automatic t_reset();
    check("R5 reset sclk", sclk, 0);
    check("R8 reset lead", lead_pulse, 0);
    check("R8 reset trail", trail_pulse, 0);
  endtask

  task automatic t_linear();
    measure("R1 N=0", {1'b1, 4'd0, 8'd0}, 1'b0);
    measure("R1 N=3", {1'b1, 4'd0, 8'd3}, 1'b0);
    measure("R1 N=9", {1'b1, 4'd0, 8'd9}, 1'b1);
  endtask

  task automatic t_exponential();
    measure("R4 M=0", {1'b0, 4'd0, 8'd0}, 1'b0);
    measure("R2 M=1", {1'b0, 4'd1, 8'd0}, 1'b0);
    measure("R2 M=3", {1'b0, 4'd3, 8'd0}, 1'b1);
    measure("R2 M=6", {1'b0, 4'd6, 8'd0}, 1'b0);
  endtask

  task automatic t_mode_select();
    measure("R3 linear ignores M", {1'b1, 4'd7, 8'd2}, 1'b0);
    measure("R3 exp ignores N", {1'b0, 4'd2, 8'd200}, 1'b0);
  endtask

  task automatic t_change_mid_run();
    int k;
    clk_ctl = {1'b1, 4'd0, 8'd3};
    cpol = 1'b0;
    repeat (3) @(negedge clk);
    run_en = 1'b1;
    wait_strobe(1'b1, k);
    clk_ctl = {1'b1, 4'd0, 8'd0};
    wait_strobe(1'b0, k);
    check("R7 rate held (trail)", k, 4);
    wait_strobe(1'b1, k);
    check("R7 rate held (lead)", k, 4);
    stop_idle();
    run_en = 1'b1;
    wait_strobe(1'b1, k);
    check("R7 new rate after restart", k, 1);
    wait_strobe(1'b0, k);
    check("R7 new rate spacing", k, 1);
    stop_idle();
  endtask

  task automatic t_stop_active();
    int k;
    clk_ctl = {1'b1, 4'd0, 8'd5};
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    run_en = 1'b1;
    wait_strobe(1'b1, k);
    check("R5 active low for cpol=1", sclk, 0);
    run_en = 1'b0;
    @(negedge clk);
    check("R8 trail on forced stop", trail_pulse, 1);
    check("R5 idle after stop", sclk, 1);
    check("R8 no lead on stop", lead_pulse, 0);
    @(negedge clk);
    check("R8 trail width", trail_pulse, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_linear();
    t_exponential();
    t_mode_select();
    t_change_mid_run();
    t_stop_active();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule